// File: doc/BRIEF.md
# Asynchronous SRAM Interface Controller

This block sits between a clocked host and an external 256K x 16 asynchronous static RAM. The host sends one request at a time over a valid/ready handshake. A request is a read or a write of one word, with an 18-bit word address, 16 bits of write data and a two-bit lane mask. The controller turns each request into a timed sequence on the RAM control pins: two chip enables of opposite polarity, output enable, write enable and one active-low enable per byte lane. For reads it registers the returned word and reports it with a one-cycle valid pulse.

Every phase length is a whole number of clock cycles. Each is derived from the clock period and a set of nanosecond minimums given as parameters, rounded up. Writes are controlled by write enable. The chip stays selected from the address-setup cycle through the hold cycle, and the address never moves while write enable is low. The data drivers stay off while output enable is low. They also stay off for the first cycles after write enable falls, which gives the RAM time to release the bus before the controller drives it.

The state machine has six states. IDLE is the ready state with the chip deselected. RD_WAIT holds the read strobes for the access time. RD_END deselects the chip and presents the read data. WR_SETUP puts out the address with write enable still high. WR_PULSE holds write enable low. WR_HOLD holds the address and data after write enable rises.

The transitions are these:
- IDLE goes to RD_WAIT on an accepted read, or to WR_SETUP on an accepted write.
- RD_WAIT goes to RD_END when its timer expires, and RD_END goes to IDLE.
- WR_SETUP goes to WR_PULSE when the mask is non-zero, or straight to WR_HOLD when the mask is zero.
- WR_PULSE goes to WR_HOLD when its timer expires.
- WR_HOLD goes to IDLE when its timer expires.

Top module: `sram_ctl`

## Requirements
- R1: While reset is asserted and after it is released, the chip is deselected (mem_ce_n high, mem_ce2 low), mem_oe_n and mem_we_n are high, mem_dq_oe and rsp_valid are low, and req_ready is high.
- R2: The chip is selected (mem_ce_n low and mem_ce2 high) only while a request is in progress. It is always selected while mem_we_n is low.
- R3: A read holds mem_oe_n low and mem_we_n high, with the address stable, for ceil(max(55,55,25) ns / period) cycles, which is 6 at 10 ns. The data is sampled at the end of the last of those cycles.
- R4: Mask bit 0 enables mem_be_n[0], the lower lane (data bits 7:0). Mask bit 1 enables mem_be_n[1], the upper lane (bits 15:8). A write changes only the enabled lanes in the RAM. A read returns zero in the disabled lanes.
- R5: On a write, mem_we_n is low for at least 45 ns. Write data is driven for at least 25 ns before mem_we_n rises.
- R6: The address is valid, with the chip selected, for at least one cycle before mem_we_n falls. It does not change while mem_we_n is low. The address and data are still driven in the cycle after mem_we_n rises.
- R7: mem_dq_oe is never high while mem_oe_n is low, nor during the first ceil(20 ns / period) cycles after mem_we_n falls.
- R8: mem_oe_n is high throughout a write request.
- R9: A write with mask 00 completes without mem_we_n ever going low and without driving the data bus, and leaves the RAM contents unchanged.
- R10: req_ready is low from the cycle after acceptance until the final phase ends. A read or a non-empty write keeps it low for 7 cycles, and a write with mask 00 for 2 cycles, at the default parameters.
- R11: rsp_valid is high for exactly one cycle per read, with rsp_rdata holding the sampled word. It is never high for a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to accept |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane mask, bit 0 lower byte, bit 1 upper byte |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 16 | Registered read data |
| mem_addr | output | 18 | RAM address |
| mem_ce_n | output | 1 | Active-low chip enable |
| mem_ce2 | output | 1 | Active-high chip enable |
| mem_oe_n | output | 1 | Active-low output enable |
| mem_we_n | output | 1 | Active-low write enable |
| mem_be_n | output | 2 | Active-low lane enables, bit 0 lower, bit 1 upper |
| mem_dq_out | output | 16 | Data toward the RAM |
| mem_dq_oe | output | 1 | Enable of the data bus drivers |
| mem_dq_in | input | 16 | Data from the RAM |

## Verification
The bench includes a RAM model that returns garbage until a read condition has been held for the access time. A controller that samples a cycle early therefore returns wrong data instead of passing by luck. The model measures each write-enable pulse and the drive window that precedes its rising edge. It flags any drive inside the bus-release window after write enable falls, and any address movement during the pulse. These catch a short pulse, a missing setup cycle, and early driving that would cause bus contention. Single-lane writes followed by full and partial reads show whether the lane enables land on the right byte. A lane swap or an unmasked read would show up as wrong bytes. An empty-mask write must leave the RAM untouched and must not pulse write enable.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

    typedef enum logic [2:0] {
        S_IDLE     = 3'd0,
        S_RD_WAIT  = 3'd1,
        S_RD_END   = 3'd2,
        S_WR_SETUP = 3'd3,
        S_WR_PULSE = 3'd4,
        S_WR_HOLD  = 3'd5
    } ctl_state_e;

    function automatic int cdiv(input int num, input int den);
        return (num + den - 1) / den;
    endfunction

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
    parameter int CNT_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - 1'b1;
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign last = (cnt == '0);

    // R10
    tmr_load_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (load_val != '0));

endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
    parameter int DATA_W = 16,
    parameter int LANES  = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_en,
    input  logic [LANES-1:0]  lane_en,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rdata,
    output logic              valid
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rdata[8*l +: 8] <= '0;
            end else if (cap_en) begin
                rdata[8*l +: 8] <= lane_en[l] ? dq_in[8*l +: 8] : 8'h00;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) valid <= 1'b0;
        else        valid <= cap_en;
    end

    // R11
    rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

endmodule

// File: rtl/sram_ctl.sv
module sram_ctl #(
    parameter int ADDR_W  = 18,
    parameter int DATA_W  = 16,
    parameter int CLK_NS  = 10,
    parameter int T_RC_NS = 55,
    parameter int T_AA_NS = 55,
    parameter int T_OE_NS = 25,
    parameter int T_WC_NS = 55,
    parameter int T_WP_NS = 45,
    parameter int T_DS_NS = 25,
    parameter int T_HZ_NS = 20
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic                  req_write,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DATA_W-1:0]     req_wdata,
    input  logic [DATA_W/8-1:0]   req_mask,
    output logic                  rsp_valid,
    output logic [DATA_W-1:0]     rsp_rdata,
    output logic [ADDR_W-1:0]     mem_addr,
    output logic                  mem_ce_n,
    output logic                  mem_ce2,
    output logic                  mem_oe_n,
    output logic                  mem_we_n,
    output logic [DATA_W/8-1:0]   mem_be_n,
    output logic [DATA_W-1:0]     mem_dq_out,
    output logic                  mem_dq_oe,
    input  logic [DATA_W-1:0]     mem_dq_in
);
    import sram_ctl_pkg::*;

    localparam int LANES    = DATA_W / 8;
    localparam int RD_CYC   = imax(imax(cdiv(T_RC_NS, CLK_NS), cdiv(T_AA_NS, CLK_NS)),
                                   cdiv(T_OE_NS, CLK_NS));
    localparam int HZ_CYC   = cdiv(T_HZ_NS, CLK_NS);
    localparam int DS_CYC   = imax(1, cdiv(T_DS_NS, CLK_NS));
    localparam int WP_CYC   = imax(cdiv(T_WP_NS, CLK_NS), HZ_CYC + DS_CYC);
    localparam int HOLD_CYC = imax(1, cdiv(T_WC_NS, CLK_NS) - 1 - WP_CYC);
    localparam int MAX_CYC  = imax(imax(RD_CYC, WP_CYC), HOLD_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam int DRV_LIM  = WP_CYC - HZ_CYC;

    ctl_state_e          state_q, state_nx;
    logic [ADDR_W-1:0]   addr_q;
    logic [DATA_W-1:0]   wdata_q;
    logic [LANES-1:0]    mask_q;
    logic                accept;
    logic                tmr_load;
    logic [CNT_W-1:0]    tmr_val;
    logic [CNT_W-1:0]    tmr_cnt;
    logic                tmr_last;
    logic                cap_en;

    assign accept = req_valid && (state_q == S_IDLE);

    // Request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
            mask_q  <= '0;
        end else if (accept) begin
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
            mask_q  <= req_mask;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    // Next state and phase timer loading
    always_comb begin
        state_nx = state_q;
        tmr_load = 1'b0;
        tmr_val  = CNT_W'(1);
        unique case (state_q)
            S_IDLE: begin
                if (accept) begin
                    if (req_write) begin
                        state_nx = S_WR_SETUP;
                    end else begin
                        state_nx = S_RD_WAIT;
                        tmr_load = 1'b1;
                        tmr_val  = CNT_W'(RD_CYC);
                    end
                end
            end
            S_RD_WAIT: begin
                if (tmr_last) state_nx = S_RD_END;
            end
            S_RD_END: begin
                state_nx = S_IDLE;
            end
            S_WR_SETUP: begin
                tmr_load = 1'b1;
                if (mask_q != '0) begin
                    state_nx = S_WR_PULSE;
                    tmr_val  = CNT_W'(WP_CYC);
                end else begin
                    state_nx = S_WR_HOLD;
                    tmr_val  = CNT_W'(1);
                end
            end
            S_WR_PULSE: begin
                if (tmr_last) begin
                    state_nx = S_WR_HOLD;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(HOLD_CYC);
                end
            end
            S_WR_HOLD: begin
                if (tmr_last) state_nx = S_IDLE;
            end
            default: state_nx = S_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        req_ready = 1'b0;
        mem_ce_n  = 1'b1;
        mem_ce2   = 1'b0;
        mem_oe_n  = 1'b1;
        mem_we_n  = 1'b1;
        mem_be_n  = '1;
        mem_dq_oe = 1'b0;
        cap_en    = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                req_ready = 1'b1;
            end
            S_RD_WAIT: begin
                mem_ce_n = 1'b0;
                mem_ce2  = 1'b1;
                mem_oe_n = 1'b0;
                mem_be_n = ~mask_q;
                cap_en   = tmr_last;
            end
            S_RD_END: begin
            end
            S_WR_SETUP: begin
                mem_ce_n = 1'b0;
                mem_ce2  = 1'b1;
                mem_be_n = ~mask_q;
            end
            S_WR_PULSE: begin
                mem_ce_n  = 1'b0;
                mem_ce2   = 1'b1;
                mem_we_n  = 1'b0;
                mem_be_n  = ~mask_q;
                mem_dq_oe = (tmr_cnt < CNT_W'(DRV_LIM));
            end
            S_WR_HOLD: begin
                mem_ce_n  = 1'b0;
                mem_ce2   = 1'b1;
                mem_be_n  = ~mask_q;
                mem_dq_oe = (mask_q != '0);
            end
            default: begin
            end
        endcase
    end

    assign mem_addr   = addr_q;
    assign mem_dq_out = wdata_q;

    sram_phase_timer #(
        .CNT_W (CNT_W)
    ) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .cnt      (tmr_cnt),
        .last     (tmr_last)
    );

    sram_rd_capture #(
        .DATA_W (DATA_W),
        .LANES  (LANES)
    ) i_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap_en  (cap_en),
        .lane_en (mask_q),
        .dq_in   (mem_dq_in),
        .rdata   (rsp_rdata),
        .valid   (rsp_valid)
    );

    // R7
    no_drive_on_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_dq_oe |-> mem_oe_n);

    // R8
    oe_high_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> mem_oe_n);

    // R2
    selected_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_we_n |-> (!mem_ce_n && mem_ce2));

    // R6
    addr_still_in_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_we_n && !$past(mem_we_n)) |-> (mem_addr == $past(mem_addr)));

    // R6
    addr_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> (!$past(mem_ce_n) && (mem_addr == $past(mem_addr))));

    // R7
    no_drive_at_we_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_we_n) |-> !mem_dq_oe);

    // R10
    busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    rsp_after_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !$past(mem_oe_n));

endmodule

// File: tb/test_sram_ctl.sv
module test_sram_ctl;

    localparam int CLK_NS  = 10;
    localparam int RD_OK   = (55 + CLK_NS - 1) / CLK_NS;
    localparam int HZ_C    = (20 + CLK_NS - 1) / CLK_NS;
    localparam int BUSY_RW = 7;
    localparam int BUSY_Z  = 2;
    localparam int NV      = 15;

    // {write, mask[1:0], addr[17:0], wdata[15:0], expect[15:0]}
    localparam logic [52:0] VEC [NV] = '{
        {1'b1, 2'b11, 18'h00010, 16'hA5C3, 16'h0000},
        {1'b0, 2'b11, 18'h00010, 16'h0000, 16'hA5C3},
        {1'b1, 2'b01, 18'h00010, 16'h1177, 16'h0000},
        {1'b0, 2'b11, 18'h00010, 16'h0000, 16'hA577},
        {1'b1, 2'b10, 18'h00010, 16'h99EE, 16'h0000},
        {1'b0, 2'b11, 18'h00010, 16'h0000, 16'h9977},
        {1'b0, 2'b01, 18'h00010, 16'h0000, 16'h0077},
        {1'b0, 2'b10, 18'h00010, 16'h0000, 16'h9900},
        {1'b1, 2'b00, 18'h00010, 16'hFFFF, 16'h0000},
        {1'b0, 2'b11, 18'h00010, 16'h0000, 16'h9977},
        {1'b1, 2'b11, 18'h3FFFF, 16'h8001, 16'h0000},
        {1'b1, 2'b11, 18'h00000, 16'h7FFE, 16'h0000},
        {1'b0, 2'b11, 18'h3FFFF, 16'h0000, 16'h8001},
        {1'b0, 2'b11, 18'h00000, 16'h0000, 16'h7FFE},
        {1'b0, 2'b00, 18'h00000, 16'h0000, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [17:0] req_addr = '0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_mask = '0;
    logic        rsp_valid;
    logic [15:0] rsp_rdata;
    logic [17:0] mem_addr;
    logic        mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
    logic [1:0]  mem_be_n;
    logic [15:0] mem_dq_out;
    logic [15:0] mem_dq_in = 16'hEEEE;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    sram_ctl i_sram_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_ready  (req_ready),
        .req_write  (req_write),
        .req_addr   (req_addr),
        .req_wdata  (req_wdata),
        .req_mask   (req_mask),
        .rsp_valid  (rsp_valid),
        .rsp_rdata  (rsp_rdata),
        .mem_addr   (mem_addr),
        .mem_ce_n   (mem_ce_n),
        .mem_ce2    (mem_ce2),
        .mem_oe_n   (mem_oe_n),
        .mem_we_n   (mem_we_n),
        .mem_be_n   (mem_be_n),
        .mem_dq_out (mem_dq_out),
        .mem_dq_oe  (mem_dq_oe),
        .mem_dq_in  (mem_dq_in)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // RAM model, evaluated away from the active edge
    logic [15:0] ram [logic [17:0]];
    logic [17:0] prev_addr = '0;
    bit          prev_we_n = 1'b1;
    bit          prev_sel  = 1'b0;
    bit          prev_rd   = 1'b0;
    int          rd_cnt = 0;
    int          wl_cnt = 0;
    int          drv_cnt = 0;
    int          we_falls = 0;
    int          drv_any = 0;
    logic [17:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [1:0]  wr_be_n = '1;

    function automatic logic [15:0] ram_rd(input logic [17:0] a);
        return ram.exists(a) ? ram[a] : 16'h0000;
    endfunction

    always @(negedge clk) begin
        if (rst_n) begin
            bit          sel;
            bit          rd;
            logic [15:0] cur;
            sel = !mem_ce_n && mem_ce2;
            rd  = sel && !mem_oe_n && mem_we_n && (mem_be_n != 2'b11);
            if (rd && prev_rd && mem_addr == prev_addr) rd_cnt++;
            else rd_cnt = rd ? 1 : 0;
            cur = ram_rd(mem_addr);
            mem_dq_in = 16'hEEEE;
            if (rd_cnt >= RD_OK) begin
                if (!mem_be_n[0]) mem_dq_in[7:0]  = cur[7:0];
                if (!mem_be_n[1]) mem_dq_in[15:8] = cur[15:8];
            end
            if (mem_dq_oe) drv_any++;
            if (!mem_we_n) begin
                if (prev_we_n) begin
                    we_falls++;
                    wl_cnt  = 0;
                    drv_cnt = 0;
                    wr_addr = mem_addr;
                    // R6 setup cycle with chip selected and same address
                    check(prev_sel && mem_addr == prev_addr, "R6 setup",
                          32'(prev_addr), 32'(mem_addr));
                end
                wl_cnt++;
                if (mem_dq_oe) begin
                    drv_cnt++;
                    if (wl_cnt <= HZ_C)
                        check(1'b0, "R7 drive in release window", 32'(wl_cnt), 32'(HZ_C + 1));
                end
                if (mem_addr != wr_addr)
                    check(1'b0, "R6 address moved in pulse", 32'(mem_addr), 32'(wr_addr));
                if (!mem_oe_n)
                    check(1'b0, "R8 oe low in write", 32'(mem_oe_n), 32'd1);
                wr_data = mem_dq_out;
                wr_be_n = mem_be_n;
            end else if (!prev_we_n) begin
                // R5 pulse width and data setup
                check(wl_cnt * CLK_NS >= 45, "R5 pulse", 32'(wl_cnt * CLK_NS), 32'd45);
                check(drv_cnt * CLK_NS >= 25, "R5 setup", 32'(drv_cnt * CLK_NS), 32'd25);
                // R6 hold after rise
                check(mem_addr == wr_addr && mem_dq_oe && mem_dq_out == wr_data && sel,
                      "R6 hold", 32'(mem_addr), 32'(wr_addr));
                cur = ram_rd(wr_addr);
                if (!wr_be_n[0]) cur[7:0]  = wr_data[7:0];
                if (!wr_be_n[1]) cur[15:8] = wr_data[15:8];
                ram[wr_addr] = cur;
            end
            prev_addr = mem_addr;
            prev_we_n = mem_we_n;
            prev_sel  = sel;
            prev_rd   = rd;
        end
    end

    task automatic run_req(input int idx, input logic [52:0] v);
        int busy = 0;
        int pulses = 0;
        int falls0 = we_falls;
        int drv0 = drv_any;
        logic [15:0] got = '0;
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = v[52];
        req_mask  = v[51:50];
        req_addr  = v[49:32];
        req_wdata = v[31:16];
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready && busy < 50) begin
            busy++;
            if (rsp_valid) begin
                pulses++;
                got = rsp_rdata;
            end
            @(negedge clk);
        end
        // R10 busy length
        check(busy == ((v[52] && v[51:50] == 2'b00) ? BUSY_Z : BUSY_RW), "R10 busy",
              32'(busy), 32'((v[52] && v[51:50] == 2'b00) ? BUSY_Z : BUSY_RW));
        // R2 deselected when idle
        check(mem_ce_n && !mem_ce2, "R2 idle deselect", {mem_ce_n, mem_ce2}, 32'b10);
        if (v[52]) begin
            // R11 no response for writes
            check(pulses == 0, "R11 write pulse", 32'(pulses), 32'd0);
            if (v[51:50] == 2'b00) begin
                // R9 empty mask
                check(we_falls == falls0 && drv_any == drv0, "R9 empty write",
                      32'(we_falls - falls0), 32'd0);
            end
        end else begin
            // R11 one pulse; R3/R4 data with lane masking
            check(pulses == 1, "R11 read pulse", 32'(pulses), 32'd1);
            check(got == v[15:0], $sformatf("R3/R4 read data vec %0d", idx),
                  32'(got), 32'(v[15:0]));
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 state during reset
        check(mem_ce_n && !mem_ce2 && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid,
              "R1 reset outputs", {mem_ce_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe, rsp_valid},
              32'b101100);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 after release
        check(req_ready && mem_ce_n && !mem_ce2 && mem_we_n && !mem_dq_oe,
              "R1 after reset", {req_ready, mem_ce_n, mem_ce2, mem_we_n, mem_dq_oe}, 32'b11010);
        for (int i = 0; i < NV; i++) run_req(i, VEC[i]);
        // R4 single lane write then the other lane stays intact
        run_req(100, {1'b1, 2'b10, 18'h00000, 16'h5511, 16'h0000});
        run_req(101, {1'b0, 2'b11, 18'h00000, 16'h0000, 16'h55FE});
        // R1 reset in the middle of a write returns to the idle outputs
        req_valid = 1'b1; req_write = 1'b1; req_mask = 2'b11;
        req_addr = 18'h00123; req_wdata = 16'h1234;
        @(negedge clk);
        req_valid = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(mem_we_n && mem_ce_n && !mem_dq_oe && req_ready, "R1 mid-write reset",
              {mem_we_n, mem_ce_n, mem_dq_oe, req_ready}, 32'b1101);
        rst_n = 1'b1;
        prev_we_n = 1'b1;
        @(negedge clk);
        run_req(102, {1'b0, 2'b11, 18'h3FFFF, 16'h0000, 16'h8001});
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 20000);
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

endmodule